// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 64-bit virtual address into a physical address by walking a three-level page table in memory. A request carries the virtual address, a two-bit privilege index, a three-bit mask of the accesses the caller needs (read, write, execute) and a flag that asks for physical bypass. The block reads page-table entries through a request/response memory read port and returns a physical address, the permissions granted and a fault code.

The block classifies each request in the cycle it is accepted. Physical bypass, malformed addresses and the kernel superpage window are answered without touching memory. All other addresses cost one memory read per level. Pages are 8 KB and the implemented virtual space is 43 bits. Only one walk is in flight at a time, and the caller sees a busy flag until the result cycle.

Top module: `pt_walker`

## Requirements
- R1: A result is a single-cycle `rsp_valid` pulse. `rsp_fault` encodes 0 = success, 1 = access violation, 2 = translation not valid, 3 = fault on read, 4 = fault on write, 5 = fault on execute. `rsp_prot` holds bit 0 = read, bit 1 = write, bit 2 = execute. `rsp_paddr` and `rsp_prot` are defined only when the fault code is 0. After reset `busy`, `rsp_valid` and `mem_req_valid` are low.
- R2: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance through the `rsp_valid` cycle, and low in the cycle after that. A request presented while `busy` is high is ignored and produces no result.
- R3: With `req_phys` set, the result is success, `rsp_paddr` equals the virtual address and `rsp_prot` is 7. No other check applies.
- R4: Outside bypass, an address whose bits 63:43 are not all equal gives an access violation.
- R5: A canonical address with bit 63 set and bits 42:41 equal to 2'b10 falls in the superpage window. At privilege 0 it succeeds with `rsp_prot` = 7 and a physical address made of virtual bits 39:0, with virtual bit 40 placed at bit 43. At any other privilege it is an access violation. No memory read is made.
- R6: Otherwise the block performs three reads. Level 1 indexes with virtual bits 42:33, level 2 with bits 32:23 and level 3 with bits 22:13. Each read address is the table base plus the index times 8. The level-1 base is `table_base` as sampled at acceptance. Each next base, and the final frame, is the entry's bits 63:32 shifted left by 13. A successful `rsp_paddr` is the frame plus virtual bits 12:0.
- R7: An entry at any level with bit 0 (valid) clear ends the walk with translation not valid.
- R8: A level-1 or level-2 entry with bit 8 (privilege-0 read enable) clear ends the walk with an access violation.
- R9: In the level-3 entry, bit 8+priv grants read and execute, and bit 12+priv grants write. If the needed mask is non-zero and none of the needed accesses is granted, the result is an access violation. A zero needed mask succeeds on any valid level-3 entry.
- R10: Level-3 bits 1, 2 and 3 withdraw read, write and execute respectively. If no needed access survives, the fault is fault on execute when execute is needed, else fault on write when write is needed, else fault on read.
- R11: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is sampled high. No new read is issued until `mem_rsp_valid` returns the data, which may come any number of cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| table_base | input | 64 | Level-1 table base, sampled at acceptance |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 64 | Virtual address |
| req_priv | input | 2 | Privilege index, 0 = kernel |
| req_need | input | 3 | Needed accesses {exec, write, read} |
| req_phys | input | 1 | Physical bypass |
| busy | output | 1 | Walk in progress or result being issued |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Page-table entry |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 3 | Fault code |
| rsp_prot | output | 3 | Granted accesses {exec, write, read} |
| rsp_paddr | output | 64 | Physical address |

## Verification
The hardest cases to reach are the fault-priority choices at level 3. Each one needs a walk whose first two levels pass, and a leaf whose enable and withdraw bits leave exactly the intended set of needed accesses. The bench builds these tables in a sparse memory model: every scenario gets its own level-1 index, and the level-3 flag patterns are chosen so that several withdraw bits compete. The memory responder varies its acceptance and data delays from read to read, so that handshake stalls land at each level. While walks are running, the bench also pokes extra requests to show that a busy walker drops them.

// File: rtl/pt_walk_pkg.sv
`timescale 1ns/1ps
package pt_walk_pkg;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ACCESS   = 3'd1,
    FLT_NOTVALID = 3'd2,
    FLT_RD_OP    = 3'd3,
    FLT_WR_OP    = 3'd4,
    FLT_EX_OP    = 3'd5
  } walk_fault_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_ISSUE,
    WS_WAIT,
    WS_DONE
  } walk_state_e;

  localparam int unsigned PERM_R = 0;
  localparam int unsigned PERM_W = 1;
  localparam int unsigned PERM_X = 2;

endpackage

// File: rtl/pt_va_decode.sv
`timescale 1ns/1ps
// Classifies a virtual address and splits out the per-level table indices.
module pt_va_decode #(
  parameter int unsigned VA_W         = 64,
  parameter int unsigned PA_W         = 64,
  parameter int unsigned PAGE_BITS    = 13,
  parameter int unsigned IMPL_VA_BITS = 43,
  parameter int unsigned IDX_W        = 10,
  parameter int unsigned LEVELS       = 3,
  parameter int unsigned SP_LOW_BITS  = 40,
  parameter int unsigned SP_RELOC_BIT = 43
) (
  input  logic [VA_W-1:0]                  va_i,
  output logic                             canonical_o,
  output logic                             superpage_o,
  output logic [PA_W-1:0]                  sp_paddr_o,
  output logic [LEVELS-1:0][IDX_W-1:0]     idx_o
);

  localparam int unsigned HI_W = VA_W - IMPL_VA_BITS;

  logic [HI_W-1:0] upper;
  assign upper       = va_i[VA_W-1:IMPL_VA_BITS];
  assign canonical_o = (&upper) | (~|upper);

  // Window selector: the two bits just below the implemented top.
  assign superpage_o = va_i[VA_W-1] && (va_i[IMPL_VA_BITS-1 -: 2] == 2'b10);

  always_comb begin
    sp_paddr_o                    = '0;
    sp_paddr_o[SP_LOW_BITS-1:0]   = va_i[SP_LOW_BITS-1:0];
    sp_paddr_o[SP_RELOC_BIT]      = va_i[SP_LOW_BITS];
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx_o[l] = va_i[PAGE_BITS + IDX_W*(LEVELS-1-l) +: IDX_W];
  end

endmodule

// File: rtl/pt_leaf_check.sv
`timescale 1ns/1ps
// Permission and fault-on-operation evaluation of the last-level entry.
module pt_leaf_check
  import pt_walk_pkg::*;
#(
  parameter int unsigned FLAG_W    = 16,
  parameter int unsigned PRIV_W    = 2,
  parameter int unsigned RD_EN_LSB = 8,
  parameter int unsigned WR_EN_LSB = 12
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [2:0]        need_i,
  output walk_fault_e       fault_o,
  output logic [2:0]        prot_o
);

  logic       grant_r, grant_w;
  logic [2:0] granted, survived;
  logic       unused_mid;

  assign grant_r  = flags_i[RD_EN_LSB + 32'(priv_i)];
  assign grant_w  = flags_i[WR_EN_LSB + 32'(priv_i)];
  assign granted  = {grant_r, grant_w, grant_r};
  // Bits 3:1 withdraw exec/write/read one-for-one.
  assign survived = granted & ~flags_i[3:1];
  assign unused_mid = ^flags_i[RD_EN_LSB-1:4];

  always_comb begin
    fault_o = FLT_NONE;
    prot_o  = survived;
    if (!flags_i[0]) begin
      fault_o = FLT_NOTVALID;
      prot_o  = '0;
    end else if ((need_i != 3'b000) && ((granted & need_i) == 3'b000)) begin
      fault_o = FLT_ACCESS;
      prot_o  = granted;
    end else if ((need_i != 3'b000) && ((survived & need_i) == 3'b000)) begin
      if (need_i[PERM_X])      fault_o = FLT_EX_OP;
      else if (need_i[PERM_W]) fault_o = FLT_WR_OP;
      else                     fault_o = FLT_RD_OP;
    end
  end

endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
// Three-level page table walker, one walk in flight.
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned VA_W         = 64,
  parameter int unsigned PA_W         = 64,
  parameter int unsigned PTE_W        = 64,
  parameter int unsigned PAGE_BITS    = 13,
  parameter int unsigned IMPL_VA_BITS = 43,
  parameter int unsigned IDX_W        = 10,
  parameter int unsigned LEVELS       = 3,
  parameter int unsigned PRIV_W       = 2,
  parameter int unsigned RD_EN_LSB    = 8,
  parameter int unsigned WR_EN_LSB    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   table_base,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic [2:0]        req_need,
  input  logic              req_phys,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              rsp_valid,
  output logic [2:0]        rsp_fault,
  output logic [2:0]        rsp_prot,
  output logic [PA_W-1:0]   rsp_paddr
);

  localparam int unsigned LVL_W      = $clog2(LEVELS);
  localparam int unsigned ENTRY_LOG2 = 3;
  localparam int unsigned FRAME_LSB  = 32;
  localparam int unsigned FLAG_W     = WR_EN_LSB + (1 << PRIV_W);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  walk_state_e          state_q, state_d;
  logic [LVL_W-1:0]     lvl_q, lvl_d;
  logic [VA_W-1:0]      va_q;
  logic [PRIV_W-1:0]    priv_q;
  logic [2:0]           need_q;
  logic                 phys_q;
  logic [PA_W-1:0]      base_q, base_d;
  walk_fault_e          fault_q, fault_d;
  logic [2:0]           prot_q, prot_d;
  logic [PA_W-1:0]      paddr_q, paddr_d;
  logic                 accept, res_en, base_en;

  logic [VA_W-1:0]             dec_va;
  logic                        canonical, superpage;
  logic [PA_W-1:0]             sp_paddr;
  logic [LEVELS-1:0][IDX_W-1:0] idx;
  walk_fault_e                 leaf_fault;
  logic [2:0]                  leaf_prot;
  logic [PA_W-1:0]             entry_frame;
  logic                        last_lvl;
  logic                        unused_pte;

  assign accept = (state_q == WS_IDLE) && req_valid;
  assign dec_va = (state_q == WS_IDLE) ? req_vaddr : va_q;

  pt_va_decode #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
    .IMPL_VA_BITS(IMPL_VA_BITS), .IDX_W(IDX_W), .LEVELS(LEVELS),
    .SP_LOW_BITS(40), .SP_RELOC_BIT(43)
  ) u_dec (
    .va_i(dec_va), .canonical_o(canonical), .superpage_o(superpage),
    .sp_paddr_o(sp_paddr), .idx_o(idx)
  );

  pt_leaf_check #(
    .FLAG_W(FLAG_W), .PRIV_W(PRIV_W),
    .RD_EN_LSB(RD_EN_LSB), .WR_EN_LSB(WR_EN_LSB)
  ) u_leaf (
    .flags_i(mem_rsp_data[FLAG_W-1:0]), .priv_i(priv_q), .need_i(need_q),
    .fault_o(leaf_fault), .prot_o(leaf_prot)
  );

  assign entry_frame = PA_W'(mem_rsp_data[PTE_W-1:FRAME_LSB]) << PAGE_BITS;
  assign last_lvl    = (lvl_q == LVL_W'(LEVELS-1));
  assign unused_pte  = ^mem_rsp_data[FRAME_LSB-1:FLAG_W];

  // Next-state process
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    base_en = 1'b0;
    res_en  = 1'b0;
    fault_d = fault_q;
    prot_d  = prot_q;
    paddr_d = paddr_q;
    unique case (state_q)
      WS_IDLE: if (req_valid) begin
        lvl_d   = '0;
        base_d  = table_base;
        base_en = 1'b1;
        res_en  = 1'b1;
        fault_d = FLT_NONE;
        prot_d  = '0;
        paddr_d = '0;
        state_d = WS_DONE;
        if (req_phys) begin
          prot_d  = 3'b111;
          paddr_d = PA_W'(req_vaddr);
        end else if (!canonical) begin
          fault_d = FLT_ACCESS;
        end else if (superpage) begin
          if (req_priv != '0) fault_d = FLT_ACCESS;
          else begin
            prot_d  = 3'b111;
            paddr_d = sp_paddr;
          end
        end else begin
          state_d = WS_ISSUE;
        end
      end
      WS_ISSUE: if (mem_req_ready) state_d = WS_WAIT;
      WS_WAIT: if (mem_rsp_valid) begin
        res_en  = 1'b1;
        state_d = WS_DONE;
        if (last_lvl) begin
          fault_d = leaf_fault;
          prot_d  = leaf_prot;
          paddr_d = entry_frame | PA_W'(va_q[PAGE_BITS-1:0]);
        end else if (!mem_rsp_data[0]) begin
          fault_d = FLT_NOTVALID;
        end else if (!mem_rsp_data[RD_EN_LSB]) begin
          fault_d = FLT_ACCESS;
        end else begin
          res_en  = 1'b0;
          base_d  = entry_frame;
          base_en = 1'b1;
          lvl_d   = lvl_q + 1'b1;
          state_d = WS_ISSUE;
        end
      end
      WS_DONE: state_d = WS_IDLE;
      default: state_d = WS_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= WS_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      priv_q  <= '0;
      need_q  <= '0;
      phys_q  <= 1'b0;
      base_q  <= '0;
      fault_q <= FLT_NONE;
      prot_q  <= '0;
      paddr_q <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      if (accept) begin
        va_q   <= req_vaddr;
        priv_q <= req_priv;
        need_q <= req_need;
        phys_q <= req_phys;
      end
      if (base_en) base_q <= base_d;
      if (res_en) begin
        fault_q <= fault_d;
        prot_q  <= prot_d;
        paddr_q <= paddr_d;
      end
    end
  end

  assign busy          = (state_q != WS_IDLE);
  assign mem_req_valid = (state_q == WS_ISSUE);
  assign mem_req_addr  = base_q + (PA_W'(idx[lvl_q]) << ENTRY_LOG2);
  assign rsp_valid     = (state_q == WS_DONE);
  assign rsp_fault     = fault_q;
  assign rsp_prot      = prot_q;
  assign rsp_paddr     = paddr_q;

  // R11: a stalled read request keeps its address.
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R11: no read issued while data is outstanding.
  a_r11_one_read: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R1/R2: a result is a single pulse followed by an idle walker.
  a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid |=> !rsp_valid && !busy);

  // R2: an accepted request makes the walker busy.
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid && !busy |=> busy);

  // R3: bypass always succeeds with every access.
  a_r3_bypass_full: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid && phys_q |-> (rsp_fault == 3'd0) && (rsp_prot == 3'b111));

  // R9/R10: success implies some needed access survived.
  a_r10_ok_has_need: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid && (rsp_fault == 3'd0) && (need_q != 3'b000) |-> (rsp_prot & need_q) != 3'b000);

endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

  logic        clk;
  logic        rst_n;
  logic [63:0] table_base;
  logic        req_valid;
  logic [63:0] req_vaddr;
  logic [1:0]  req_priv;
  logic [2:0]  req_need;
  logic        req_phys;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [2:0]  rsp_prot;
  logic [63:0] rsp_paddr;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .table_base(table_base),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_priv(req_priv),
    .req_need(req_need), .req_phys(req_phys), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_prot(rsp_prot), .rsp_paddr(rsp_paddr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [2:0]  fault;
    logic [2:0]  prot;
    logic [63:0] paddr;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] pmem [logic [63:0]];
  int checks = 0, errors = 0, n_sent = 0, n_rsp = 0, lat_sel = 0;
  bit done = 0;

  localparam logic [63:0] BASE = 64'h0000_0000_0010_0000;
  localparam logic [31:0] T2 = 32'h0000_0200, T3 = 32'h0000_0300;

  task automatic fail(string rq, string what, logic [63:0] act, logic [63:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
  endtask

  function automatic logic [63:0] rd(logic [63:0] a);
    return pmem.exists(a) ? pmem[a] : 64'h0;
  endfunction

  // Expected result from the requirements (R3..R10).
  function automatic exp_t model(logic [63:0] va, logic [1:0] pv, logic [2:0] nd,
                                 logic ph, string tag);
    exp_t e;
    logic [63:0] b, pte;
    logic [2:0] g, m;
    e.fault = 0; e.prot = 0; e.paddr = 0; e.tag = tag;
    b = BASE;
    if (ph) begin e.prot = 3'b111; e.paddr = va; return e; end
    if (!(va[63:43] == '1 || va[63:43] == '0)) begin e.fault = 1; return e; end
    if (va[63] && va[42:41] == 2'b10) begin
      if (pv != 0) begin e.fault = 1; return e; end
      e.prot = 3'b111;
      e.paddr = {20'h0, va[40], 3'b000, va[39:0]};
      return e;
    end
    for (int lv = 0; lv < 3; lv++) begin
      pte = rd(b + {51'h0, va[13 + 10*(2-lv) +: 10], 3'b000});
      if (!pte[0]) begin e.fault = 2; return e; end
      if (lv < 2) begin
        if (!pte[8]) begin e.fault = 1; return e; end
        b = {19'h0, pte[63:32], 13'h0};
      end else begin
        g = {pte[8+pv], pte[12+pv], pte[8+pv]};
        m = g & ~pte[3:1];
        e.paddr = {19'h0, pte[63:32], va[12:0]};
        e.prot = m;
        if (nd != 0 && (g & nd) == 0) e.fault = 1;
        else if (nd != 0 && (m & nd) == 0) e.fault = nd[2] ? 3'd5 : nd[1] ? 3'd4 : 3'd3;
      end
    end
    return e;
  endfunction

  function automatic logic [63:0] mkva(int i1, int i2, int i3, int off);
    return {21'h0, 10'(i1), 10'(i2), 10'(i3), 13'(off)};
  endfunction

  task automatic map(logic [63:0] va, logic [31:0] f1, logic [31:0] f2,
                     logic [31:0] f3, logic [31:0] frame);
    pmem[BASE + {51'h0, va[42:33], 3'b000}] = {T2, f1};
    pmem[{19'h0, T2, 13'h0} + {51'h0, va[32:23], 3'b000}] = {T3, f2};
    pmem[{19'h0, T3, 13'h0} + {51'h0, va[22:13], 3'b000}] = {frame, f3};
  endtask

  // Driver: pushes the expected result, then presents the request.
  task automatic send(logic [63:0] va, logic [1:0] pv, logic [2:0] nd,
                      logic ph, bit poke, string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    sb.push_back(model(va, pv, nd, ph, tag));
    n_sent++;
    req_valid = 1; req_vaddr = va; req_priv = pv; req_need = nd; req_phys = ph;
    @(negedge clk);
    req_valid = 0;
    checks++;
    if (!busy) fail("R2", "busy after accept", {63'h0, busy}, 64'h1);
    if (poke) begin
      // R2: ignored while busy
      req_valid = 1; req_vaddr = 64'h1234; req_phys = 1;
      @(negedge clk);
      req_valid = 0; req_phys = 0;
    end
  endtask

  // Memory responder with varying delays (R11).
  initial begin
    logic [63:0] a;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        a = mem_req_addr;
        repeat (lat_sel % 3) @(negedge clk);
        checks++;
        if (!mem_req_valid || mem_req_addr != a)
          fail("R11", "stalled request address", mem_req_addr, a);
        mem_req_ready = 1;
        @(negedge clk);
        mem_req_ready = 0;
        for (int k = 0; k < (lat_sel % 4); k++) begin
          if (mem_req_valid) fail("R11", "second read while outstanding", 64'h1, 64'h0);
          @(negedge clk);
        end
        mem_rsp_data = rd(a); mem_rsp_valid = 1;
        @(negedge clk);
        mem_rsp_valid = 0;
        lat_sel++;
      end
    end
  end

  // Monitor: pops the scoreboard on every result.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        n_rsp++;
        checks++;
        if (!busy) fail("R2", "busy during result", 64'h0, 64'h1);
        if (sb.size() == 0) begin
          fail("R2", "unexpected result", 64'(n_rsp), 64'(n_sent));
        end else begin
          e = sb.pop_front();
          checks++;
          if (rsp_fault != e.fault) fail(e.tag, "fault", 64'(rsp_fault), 64'(e.fault));
          else if (e.fault == 0) begin
            if (rsp_prot != e.prot) fail(e.tag, "prot", 64'(rsp_prot), 64'(e.prot));
            if (rsp_paddr != e.paddr) fail(e.tag, "paddr", rsp_paddr, e.paddr);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_vaddr = 0; req_priv = 0; req_need = 0;
    req_phys = 0; table_base = BASE;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (busy || rsp_valid || mem_req_valid)
      fail("R1", "reset outputs", {61'h0, busy, rsp_valid, mem_req_valid}, 64'h0);

    // Page tables: flags bit0 valid, 1/2/3 withdraw r/w/x, 8+p read, 12+p write.
    map(mkva(1, 5, 7, 'h123), 32'h101, 32'h101, 32'h1101, 32'h12345);
    map(mkva(2, 1, 1, 0),     32'h101, 32'h101, 32'h1F01, 32'h22);
    map(mkva(3, 0, 0, 0),     32'h100, 32'h101, 32'h1101, 32'h33);
    map(mkva(4, 0, 0, 0),     32'h101, 32'h001, 32'h1101, 32'h44);
    map(mkva(5, 0, 0, 0),     32'h101, 32'h101, 32'h1100, 32'h55);
    map(mkva(6, 2, 3, 0),     32'h101, 32'h101, 32'h0103, 32'h66);
    map(mkva(7, 2, 3, 0),     32'h101, 32'h101, 32'h110F, 32'h77);
    map(mkva(8, 2, 3, 0),     32'h101, 32'h101, 32'h1107, 32'h88);
    map(mkva(9, 2, 3, 0),     32'h101, 32'h101, 32'h0001, 32'h99);
    map(mkva(10, 2, 3, 'h1FFF), 32'h101, 32'h101, 32'h0109, 32'hAA);
    map(mkva(11, 3, 4, 0),    32'h101, 32'h101, 32'h3301, 32'hBB);

    send(64'h0000_1000_0000_0000, 0, 3'b001, 1, 0, "R3");          // bypass wins over canonical check
    send(64'hFFFF_FFFF_FFFF_0000, 2, 3'b111, 1, 1, "R3");
    send(64'h0000_1000_0000_0000, 0, 3'b001, 0, 0, "R4");          // bit 44 set, bit 63 clear
    send(64'h8000_0000_0000_0000, 0, 3'b001, 0, 0, "R4");
    send({21'h1FFFFF, 2'b10, 41'h1_23_4567_89AB}, 0, 3'b010, 0, 1, "R5");
    send({21'h1FFFFF, 2'b10, 41'h0_00_0000_1000}, 0, 3'b001, 0, 0, "R5");
    send({21'h1FFFFF, 2'b10, 41'h1_00_0000_0000}, 3, 3'b001, 0, 0, "R5");
    send(mkva(1, 5, 7, 'h123), 0, 3'b001, 0, 1, "R6");
    send(mkva(1, 5, 7, 'h123), 0, 3'b100, 0, 0, "R6");
    send(64'hFFFF_FFFF_FFFF_E000, 0, 3'b001, 0, 0, "R7");         // negative, unmapped
    send(mkva(3, 0, 0, 0), 0, 3'b001, 0, 0, "R7");
    send(mkva(5, 0, 0, 0), 0, 3'b001, 0, 0, "R7");
    send(mkva(4, 0, 0, 0), 0, 3'b001, 0, 0, "R8");
    send(mkva(2, 1, 1, 0), 2, 3'b010, 0, 0, "R9");                 // no write at priv 2
    send(mkva(2, 1, 1, 0), 0, 3'b010, 0, 0, "R9");
    send(mkva(11, 3, 4, 0), 1, 3'b010, 0, 0, "R9");                // write via bit 13
    send(mkva(11, 3, 4, 0), 3, 3'b001, 0, 0, "R9");                // nothing at priv 3
    send(mkva(9, 2, 3, 0), 0, 3'b000, 0, 0, "R9");                 // zero need
    send(mkva(6, 2, 3, 0), 0, 3'b001, 0, 0, "R10");                // fault on read
    send(mkva(7, 2, 3, 0), 0, 3'b111, 0, 1, "R10");                // exec first
    send(mkva(8, 2, 3, 0), 0, 3'b011, 0, 0, "R10");                // write before read
    send(mkva(10, 2, 3, 'h1FFF), 0, 3'b101, 0, 0, "R10");          // read survives

    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    checks++;
    if (n_rsp != n_sent) fail("R2", "result count", 64'(n_rsp), 64'(n_sent));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule